// File: doc/BRIEF.md
# Banked Memory Map Decoder with Sprite-DMA Bus Arbitration

This block sits between an 8-bit CPU and the storage of a handheld console. It takes each CPU read or write on the 16-bit address bus and works out which storage region the access targets. It produces the region select and the address local to that region. It then lets the storage strobe through, or withholds it, according to the video mode and to any sprite DMA transfer in progress. Read data from every region comes back one cycle later, as it would from synchronous RAM. A registered select then picks the right byte, or forces the floating-bus value 0xFF when the access was refused.

The storage arrays, the cartridge bank controller and the DMA engine lie outside the block. The DMA engine reports only whether it is busy and which source address it is reading. The CPU side supplies the work-RAM bank number through a load strobe. A model input chooses between the original console and the colour console, and the two differ in how the address space is split into buses.

Top module: `banked_map_arbiter`

## Requirements
- R1: `region_sel` decodes the address with these codes: 0x0000–0x3FFF gives 0 (fixed ROM), 0x4000–0x7FFF gives 1 (switchable ROM), 0x8000–0x9FFF gives 2 (video RAM), 0xA000–0xBFFF gives 3 (external RAM), 0xC000–0xCFFF gives 4 (work RAM low), 0xD000–0xDFFF gives 5 (work RAM banked). `local_addr` is addr[13:0] for ROM, addr[12:0] for video and external RAM, and addr[11:0] for work RAM low.
- R2: 0xE000–0xEFFF mirrors work RAM low (code 4) and 0xF000–0xFDFF mirrors the banked work RAM (code 5), each with the same local address as the mirrored location.
- R3: 0xFE00–0xFE9F gives code 6 (sprite RAM, local addr[7:0]). 0xFEA0–0xFEFF gives code 7 (unusable): it reads 0xFF and never raises `mem_re` or `mem_we`. 0xFF00–0xFF7F gives code 8 (I/O, local addr[6:0]). 0xFF80–0xFFFE gives code 9 (high RAM, local addr[6:0]). 0xFFFF gives code 10 (interrupt enable, local 0).
- R4: The banked work-RAM local address is {bank, addr[11:0]}, where bank is the 3-bit value last loaded through `bank_load`. A loaded value of 0 selects bank 1.
- R5: A read at an address below 0x8000 that is at or above `rom_size` returns 0xFF and does not raise `mem_re`. Writes to ROM are not affected by `rom_size`.
- R6: While `vid_mode` equals 3, video-RAM reads return 0xFF and video-RAM writes do not raise `mem_we`.
- R7: Sprite RAM is reachable only while `vid_mode` is 0 or 1. In modes 2 and 3, reads return 0xFF and writes are dropped.
- R8: Each 8 KB slice addr[15:13] has a bus class. Slice 4 is the video bus and slice 7 is the CPU-local bus. With `color_model`=1, slice 6 is the work-RAM bus. Every other slice is the main bus. While `dma_busy` is high, an access whose class equals the class of `dma_src` reads 0xFF and is not strobed, unless that class is the CPU-local bus.
- R9: While `dma_busy` is high, reads and writes at 0xFE00–0xFE9F return 0xFF or are dropped, whatever the video mode.
- R10: After a cycle with `rd_en` high, `rd_valid` is high in the next cycle and `rd_data` equals byte slot `region` of `src_rdata` (bits 8k+7:8k for code k), or 0xFF if the read was refused. After a cycle without `rd_en`, `rd_valid` is low.
- R11: After reset, `rd_valid` is low and the work-RAM bank is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe |
| vid_mode | input | 2 | Current video mode (0..3) |
| dma_busy | input | 1 | Sprite DMA transfer in progress |
| dma_src | input | 16 | Address the DMA is currently reading |
| color_model | input | 1 | 1 selects the colour console's bus classes |
| rom_size | input | 16 | ROM size in bytes (up to 0x8000) |
| bank_load | input | 1 | Load the work-RAM bank number |
| bank_value | input | 3 | Bank number to load |
| src_rdata | input | 88 | Region read bytes, slot k for region code k |
| region_sel | output | 4 | Decoded region code |
| local_addr | output | 15 | Address within the region |
| mem_re | output | 1 | Gated read strobe to storage |
| mem_we | output | 1 | Gated write strobe to storage |
| rd_data | output | 8 | Read data, one cycle after the read |
| rd_valid | output | 1 | `rd_data` holds a read result |

## Verification
The block's state is small: the bank number, and the region code and refusal flag held for one cycle. Each of them shows at the ports within one access. A wrong bank appears in `local_addr` on the first banked access. A wrong held region or refusal flag corrupts `rd_data` in the cycle right after the read. A decode or arbitration error shows up at once in `region_sel`, `mem_re` or `mem_we` in the same cycle as the access. Sweeping addresses across every video mode, DMA source slice and model therefore exposes faults within a cycle or two of the access that triggers them.

// File: rtl/map_pkg.sv
package map_pkg;

    localparam int BYTE_W      = 8;
    localparam int REGION_W    = 4;
    localparam int NUM_REGIONS = 11;
    localparam int NUM_SLOTS   = 1 << REGION_W;

    typedef enum logic [REGION_W-1:0] {
        RG_ROM_FIX  = 4'd0,
        RG_ROM_SW   = 4'd1,
        RG_VRAM     = 4'd2,
        RG_XRAM     = 4'd3,
        RG_WRAM_LO  = 4'd4,
        RG_WRAM_HI  = 4'd5,
        RG_OAM      = 4'd6,
        RG_VOID     = 4'd7,
        RG_IO       = 4'd8,
        RG_HRAM     = 4'd9,
        RG_IE       = 4'd10
    } region_t;

    typedef enum logic [1:0] {
        BC_CPU  = 2'd0,
        BC_MAIN = 2'd1,
        BC_VID  = 2'd2,
        BC_WRAM = 2'd3
    } bus_class_t;

    function automatic bus_class_t slice_class(input logic [2:0] slice, input logic color);
        bus_class_t c;
        unique case (slice)
            3'd4:    c = BC_VID;
            3'd6:    c = color ? BC_WRAM : BC_MAIN;
            3'd7:    c = BC_CPU;
            default: c = BC_MAIN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/region_decode.sv
module region_decode
    import map_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int LOC_W = 12 + BANK_W
) (
    input  logic [15:0]       addr,
    input  logic [BANK_W-1:0] bank,
    output region_t           region,
    output logic [LOC_W-1:0]  local_addr
);

    always_comb begin
        region     = RG_VOID;
        local_addr = '0;
        unique case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: begin
                region     = RG_ROM_FIX;
                local_addr = LOC_W'(addr[13:0]);
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                region     = RG_ROM_SW;
                local_addr = LOC_W'(addr[13:0]);
            end
            4'h8, 4'h9: begin
                region     = RG_VRAM;
                local_addr = LOC_W'(addr[12:0]);
            end
            4'hA, 4'hB: begin
                region     = RG_XRAM;
                local_addr = LOC_W'(addr[12:0]);
            end
            4'hC, 4'hE: begin
                region     = RG_WRAM_LO;
                local_addr = LOC_W'(addr[11:0]);
            end
            4'hD: begin
                region     = RG_WRAM_HI;
                local_addr = {bank, addr[11:0]};
            end
            4'hF: begin
                if (addr < 16'hFE00) begin
                    region     = RG_WRAM_HI;
                    local_addr = {bank, addr[11:0]};
                end else if (addr < 16'hFEA0) begin
                    region     = RG_OAM;
                    local_addr = LOC_W'(addr[7:0]);
                end else if (addr < 16'hFF00) begin
                    region     = RG_VOID;
                end else if (addr < 16'hFF80) begin
                    region     = RG_IO;
                    local_addr = LOC_W'(addr[6:0]);
                end else if (addr != 16'hFFFF) begin
                    region     = RG_HRAM;
                    local_addr = LOC_W'(addr[6:0]);
                end else begin
                    region     = RG_IE;
                end
            end
        endcase
    end

endmodule

// File: rtl/bus_guard.sv
module bus_guard
    import map_pkg::*;
(
    input  logic [15:0] addr,
    input  region_t     region,
    input  logic [1:0]  vid_mode,
    input  logic        dma_busy,
    input  logic [15:0] dma_src,
    input  logic        color_model,
    input  logic [15:0] rom_size,
    output logic        rd_block,
    output logic        wr_block
);

    bus_class_t acc_class;
    bus_class_t dma_class;
    logic       dma_clash;
    logic       dma_oam;
    logic       video_busy;
    logic       rom_beyond;
    logic       void_hit;

    always_comb begin
        acc_class  = slice_class(addr[15:13], color_model);
        dma_class  = slice_class(dma_src[15:13], color_model);
        dma_clash  = dma_busy && (acc_class == dma_class) && (dma_class != BC_CPU);
        dma_oam    = dma_busy && (addr >= 16'hFE00) && (addr < 16'hFEA0);
        video_busy = ((region == RG_VRAM) && (vid_mode == 2'd3)) ||
                     ((region == RG_OAM) && vid_mode[1]);
        rom_beyond = ((region == RG_ROM_FIX) || (region == RG_ROM_SW)) && (addr >= rom_size);
        void_hit   = (region == RG_VOID);
        wr_block   = dma_clash || dma_oam || video_busy || void_hit;
        rd_block   = wr_block || rom_beyond;
    end

endmodule

// File: rtl/wram_bank_reg.sv
module wram_bank_reg #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] value,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] FIRST_BANK = BANK_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= FIRST_BANK;
        end else if (load) begin
            bank <= (value == '0) ? FIRST_BANK : value;
        end
    end

endmodule

// File: rtl/banked_map_arbiter.sv
module banked_map_arbiter
    import map_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int LOC_W = 12 + BANK_W,
    localparam int SRC_W = NUM_REGIONS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        vid_mode,
    input  logic              dma_busy,
    input  logic [15:0]       dma_src,
    input  logic              color_model,
    input  logic [15:0]       rom_size,
    input  logic              bank_load,
    input  logic [BANK_W-1:0] bank_value,
    input  logic [SRC_W-1:0]  src_rdata,
    output logic [REGION_W-1:0] region_sel,
    output logic [LOC_W-1:0]  local_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [BANK_W-1:0] bank;
    region_t           region;
    logic              rd_block;
    logic              wr_block;
    region_t           region_q;
    logic              refuse_q;
    logic [BYTE_W-1:0] slot [NUM_SLOTS];

    wram_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bank_load),
        .value (bank_value),
        .bank  (bank)
    );

    region_decode #(.BANK_W(BANK_W)) u_decode (
        .addr       (cpu_addr),
        .bank       (bank),
        .region     (region),
        .local_addr (local_addr)
    );

    bus_guard u_guard (
        .addr        (cpu_addr),
        .region      (region),
        .vid_mode    (vid_mode),
        .dma_busy    (dma_busy),
        .dma_src     (dma_src),
        .color_model (color_model),
        .rom_size    (rom_size),
        .rd_block    (rd_block),
        .wr_block    (wr_block)
    );

    assign region_sel = region;
    assign mem_re     = rd_en && !rd_block;
    assign mem_we     = wr_en && !wr_block;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        if (k < NUM_REGIONS) begin : g_live
            assign slot[k] = src_rdata[k*BYTE_W +: BYTE_W];
        end else begin : g_dead
            assign slot[k] = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= RG_VOID;
            refuse_q <= 1'b1;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                region_q <= region;
                refuse_q <= rd_block;
            end
        end
    end

    always_comb begin
        rd_data = refuse_q ? '1 : slot[region_q];
    end

endmodule

// File: rtl/map_guard_chk.sv
module map_guard_chk #(
    parameter int LOC_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      cpu_addr,
    input logic             rd_en,
    input logic             wr_en,
    input logic [1:0]       vid_mode,
    input logic             dma_busy,
    input logic [15:0]      rom_size,
    input logic [3:0]       region_sel,
    input logic [LOC_W-1:0] local_addr,
    input logic             mem_re,
    input logic             mem_we,
    input logic [7:0]       rd_data,
    input logic             rd_valid
);

    assert_mirror_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:12] == 4'hE) |-> (region_sel == 4'd4));

    assert_void_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == 4'd7) |-> (!mem_re && !mem_we));

    assert_bank_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == 4'd5) |-> (local_addr[LOC_W-1:12] != '0));

    assert_rom_beyond_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cpu_addr < 16'h8000 && cpu_addr >= rom_size) |=> (rd_data == 8'hFF));

    assert_vram_mode3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == 4'd2 && vid_mode == 2'd3) |-> (!mem_re && !mem_we));

    assert_oam_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (region_sel == 4'd6 && vid_mode[1]) |-> (!mem_re && !mem_we));

    assert_oam_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_busy && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0) |-> (!mem_re && !mem_we));

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

bind banked_map_arbiter map_guard_chk #(.LOC_W(LOC_W)) u_map_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .vid_mode   (vid_mode),
    .dma_busy   (dma_busy),
    .rom_size   (rom_size),
    .region_sel (region_sel),
    .local_addr (local_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
);

// File: tb/banked_map_arbiter_test.sv
module banked_map_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  vid_mode = '0;
    logic        dma_busy = 1'b0;
    logic [15:0] dma_src = '0;
    logic        color_model = 1'b0;
    logic [15:0] rom_size = 16'h6000;
    logic        bank_load = 1'b0;
    logic [2:0]  bank_value = '0;
    logic [87:0] src_rdata;
    logic [3:0]  region_sel;
    logic [14:0] local_addr;
    logic        mem_re;
    logic        mem_we;
    logic [7:0]  rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    int cur_bank = 1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    initial begin
        for (int k = 0; k < 11; k++) src_rdata[k*8 +: 8] = 8'(8'h30 + k);
    end

    banked_map_arbiter uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .rd_en(rd_en), .wr_en(wr_en),
        .vid_mode(vid_mode), .dma_busy(dma_busy), .dma_src(dma_src),
        .color_model(color_model), .rom_size(rom_size), .bank_load(bank_load),
        .bank_value(bank_value), .src_rdata(src_rdata), .region_sel(region_sel),
        .local_addr(local_addr), .mem_re(mem_re), .mem_we(mem_we),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h mode %0d dma %0d src 0x%04h color %0d)",
                     tag, act, exp, cpu_addr, vid_mode, dma_busy, dma_src, color_model);
        end
    endtask

    function automatic int exp_region(input int a);
        if (a < 16'h4000) return 0;
        if (a < 16'h8000) return 1;
        if (a < 16'hA000) return 2;
        if (a < 16'hC000) return 3;
        if (a < 16'hD000) return 4;
        if (a < 16'hE000) return 5;
        if (a < 16'hF000) return 4;
        if (a < 16'hFE00) return 5;
        if (a < 16'hFEA0) return 6;
        if (a < 16'hFF00) return 7;
        if (a < 16'hFF80) return 8;
        if (a < 16'hFFFF) return 9;
        return 10;
    endfunction

    function automatic int exp_local(input int a, input int bnk);
        case (exp_region(a))
            0, 1:    return a % 16384;
            2, 3:    return a % 8192;
            4:       return a % 4096;
            5:       return bnk * 4096 + a % 4096;
            6:       return a % 256;
            8, 9:    return a % 128;
            default: return 0;
        endcase
    endfunction

    function automatic int bus_of(input int a, input bit color);
        int s = a / 8192;
        if (s == 7) return 0;
        if (s == 4) return 2;
        if (s == 6 && color) return 3;
        return 1;
    endfunction

    function automatic bit exp_wblock(input int a);
        int r = exp_region(a);
        if (dma_busy && bus_of(a, color_model) == bus_of(int'(dma_src), color_model) &&
            bus_of(int'(dma_src), color_model) != 0) return 1;
        if (dma_busy && a >= 16'hFE00 && a < 16'hFEA0) return 1;
        if (r == 2 && vid_mode == 3) return 1;
        if (r == 6 && vid_mode >= 2) return 1;
        if (r == 7) return 1;
        return 0;
    endfunction

    function automatic bit exp_rblock(input int a);
        return exp_wblock(a) || (a < 16'h8000 && a >= int'(rom_size));
    endfunction

    task automatic do_read(input int a);
        int er;
        bit blk;
        @(negedge clk);
        cpu_addr = 16'(a); rd_en = 1'b1; wr_en = 1'b0;
        #1;
        er  = exp_region(a);
        blk = exp_rblock(a);
        chk(region_sel == 4'(er), "R1/R2/R3 region", int'(region_sel), er);
        chk(local_addr == 15'(exp_local(a, cur_bank)), "R1/R2/R4 local_addr", int'(local_addr), exp_local(a, cur_bank));
        chk(mem_re == !blk, "R5/R6/R7/R8/R9 mem_re", int'(mem_re), int'(!blk));
        @(negedge clk);
        chk(rd_valid == 1'b1, "R10 rd_valid", int'(rd_valid), 1);
        chk(rd_data == (blk ? 8'hFF : 8'(8'h30 + er)), "R10 rd_data", int'(rd_data),
            blk ? 255 : 8'h30 + er);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input int a);
        bit blk;
        @(negedge clk);
        cpu_addr = 16'(a); wr_en = 1'b1; rd_en = 1'b0;
        #1;
        blk = exp_wblock(a);
        chk(mem_we == !blk, "R3/R6/R7/R8/R9 mem_we", int'(mem_we), int'(!blk));
        chk(mem_re == 1'b0, "R3 mem_re on write", int'(mem_re), 0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_bank(input int v);
        @(negedge clk);
        bank_load = 1'b1; bank_value = 3'(v);
        @(negedge clk);
        bank_load = 1'b0;
        cur_bank = (v == 0) ? 1 : v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int bnd [16] = '{16'hDFFF, 16'hE000, 16'hEFFF, 16'hF000, 16'hFDFF, 16'hFE00,
                         16'hFE9F, 16'hFEA0, 16'hFEFF, 16'hFF00, 16'hFF7F, 16'hFF80,
                         16'hFFFE, 16'hFFFF, 16'h5FFF, 16'h6000};
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rd_valid == 1'b0, "R11 rd_valid after reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cpu_addr = 16'hD234;
        #1;
        chk(local_addr == 15'h1234, "R11 reset bank is 1", int'(local_addr), 16'h1234);
        chk(rd_valid == 1'b0, "R10 idle rd_valid", int'(rd_valid), 0);

        // sweep: model x DMA source slice x video mode x addresses
        for (int col = 0; col < 2; col++) begin
            for (int d = 0; d < 9; d++) begin
                for (int m = 0; m < 4; m++) begin
                    color_model = col[0];
                    dma_busy = (d != 0);
                    dma_src  = (d == 0) ? 16'h0000 : 16'(((d - 1) * 8192) + 16'h0123);
                    vid_mode = 2'(m);
                    for (int i = 0; i < 256; i++) begin
                        int a = i * 256 + ((i * 37) % 256);
                        do_read(a);
                        do_write(a);
                    end
                    for (int j = 0; j < 16; j++) do_read(bnd[j]);
                end
            end
        end
        dma_busy = 1'b0; vid_mode = 2'd0; color_model = 1'b0;

        // R4: bank loads, including 0 -> 1
        for (int v = 0; v < 8; v++) begin
            load_bank(v);
            do_read(16'hD5A5);
            do_read(16'hF5A5);
        end
        load_bank(0);
        @(negedge clk);
        cpu_addr = 16'hDFFF;
        #1;
        chk(local_addr == 15'h1FFF, "R4 bank 0 selects 1", int'(local_addr), 16'h1FFF);

        // R5: ROM size boundaries
        rom_size = 16'h2000;
        do_read(16'h1FFF);
        do_read(16'h2000);
        do_write(16'h2000);
        rom_size = 16'h8000;
        do_read(16'h7FFF);
        do_read(16'h4000);

        // R10: rd_valid falls after an idle cycle
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 rd_valid idle", int'(rd_valid), 0);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule